// File: doc/BRIEF.md
# GPIO Controller with Level and Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for up to 32 pins. Software reaches it over a plain 32-bit register bus. Each pin has an output value and an output enable that drive the pad. The incoming pin state passes through a synchronizer and can be read back.

Every pin can request an interrupt in two ways. A level source is evaluated live from the synchronized pin, with a selectable active polarity and a mask. An edge source catches either a rising or a falling transition into a sticky event bit, which is cleared by writing one; it has a mask of its own. The masked level sources and the masked edge sources are merged into one summary status bit in a second, small register region. A mask bit in that region gates the summary onto a single registered interrupt line.

The bus carries a region select. Region 0 holds the per-pin registers and region 1 holds the summary status and its mask. A read returns its data on the clock edge that follows the request.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every readable register returns 0, `irq` is 0 and `pad_oe` is 0.
- R2: Region 0 offset 0x00 returns the pin inputs after a two-flop synchronizer, zero-extended; writes to it are ignored.
- R3: Region 0 offset 0x04 holds the output values and offset 0x08 holds the output enables. `pad_oe` equals the enable register, and `pad_out` equals output AND enable, so a released pad drives 0.
- R4: A pin's level source is pending when (synchronized input XOR polarity bit) AND level-mask bit is 1. The polarity register is at region 0 offset 0x10, where bit value 0 means active high and 1 means active low. The level-mask register is at offset 0x14.
- R5: The edge-select register is at region 0 offset 0x24, where bit value 0 picks rising edges and 1 picks falling edges. A transition of the selected kind on a synchronized pin sets that pin's bit in the event register at offset 0x18. A transition of the other kind leaves the bit unchanged.
- R6: Writing a 1 to an event bit at offset 0x18 clears it, and writing a 0 leaves it unchanged. No other action clears an event bit.
- R7: If a new edge and a clearing write reach the same event bit in the same cycle, the bit ends up set.
- R8: A pin's edge source is pending when its event bit AND its event-mask bit are 1. The event-mask register is at region 0 offset 0x1C. Region 1 offset 0x20 bit 0 reads 1 exactly when any level or edge source is pending. Writes to that status register are ignored.
- R9: Region 1 offset 0x24 bit 0 is the summary mask. `irq` is a register loaded each cycle with (status bit 0 AND summary mask bit 0).
- R10: Reads of unmapped offsets return 0, and writes to unmapped offsets change no register. Examples are region 0 offsets 0x0C and 0x20, and region 1 offset 0x00.
- R11: Register bits at positions NUM_PINS and above read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request in this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_region | input | 1 | 0 selects the pin region, 1 selects the summary region |
| bus_addr | input | ADDR_W | Byte offset within the region |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle after a read request |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pad_out | output | NUM_PINS | Pad output value, 0 when the pad is released |
| pad_oe | output | NUM_PINS | Pad output enable |
| irq | output | 1 | Registered interrupt line |

## Verification
The assertions assume that reset is held for at least one clock before any check applies. They also assume that `pin_in` is the only source of events, so every event bit that rises can be traced to a synchronized transition seen one cycle earlier. The bench changes pins only on falling clock edges and waits several cycles for the synchronizer to settle before it samples. It issues at most one bus request per cycle. It also forces a clearing write into the exact cycle in which an edge reaches the event register, so the case where a set and a clear hit the same bit is exercised on purpose.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // Byte offsets within the pin region
  localparam int unsigned OFS_PIN_IN   = 'h00;
  localparam int unsigned OFS_PIN_OUT  = 'h04;
  localparam int unsigned OFS_PIN_OE   = 'h08;
  localparam int unsigned OFS_LVL_POL  = 'h10;
  localparam int unsigned OFS_LVL_MSK  = 'h14;
  localparam int unsigned OFS_EVT      = 'h18;
  localparam int unsigned OFS_EVT_MSK  = 'h1C;
  localparam int unsigned OFS_EDGE_SEL = 'h24;
  // Byte offsets within the summary region
  localparam int unsigned OFS_TOP_STS  = 'h20;
  localparam int unsigned OFS_TOP_MSK  = 'h24;

  typedef enum logic {
    REGION_PIN = 1'b0,
    REGION_TOP = 1'b1
  } region_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] sync_q,
  output logic [W-1:0] prev_q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      prev_q <= '0;
    end else begin
      chain[0] <= din;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      prev_q <= chain[STAGES-1];
    end
  end

  assign sync_q = chain[STAGES-1];
endmodule

// File: rtl/gpio_edge_events.sv
module gpio_edge_events #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sync_q,
  input  logic [W-1:0] prev_q,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] clr,
  output logic [W-1:0] hit,
  output logic [W-1:0] ev_q
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    logic rise, fall;
    assign rise   = sync_q[g] & ~prev_q[g];
    assign fall   = ~sync_q[g] & prev_q[g];
    assign hit[g] = edge_sel[g] ? fall : rise;
  end

  // a new edge takes precedence over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) ev_q <= '0;
    else     ev_q <= (ev_q & ~clr) | hit;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NUM_PINS    = 8,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic                bus_region,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq
);
  import gpio_irq_pkg::*;

  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFS_PIN_IN);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OFS_PIN_OUT);
  localparam logic [ADDR_W-1:0] A_OE   = ADDR_W'(OFS_PIN_OE);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(OFS_LVL_POL);
  localparam logic [ADDR_W-1:0] A_LMSK = ADDR_W'(OFS_LVL_MSK);
  localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(OFS_EVT);
  localparam logic [ADDR_W-1:0] A_EMSK = ADDR_W'(OFS_EVT_MSK);
  localparam logic [ADDR_W-1:0] A_ESEL = ADDR_W'(OFS_EDGE_SEL);
  localparam logic [ADDR_W-1:0] A_TSTS = ADDR_W'(OFS_TOP_STS);
  localparam logic [ADDR_W-1:0] A_TMSK = ADDR_W'(OFS_TOP_MSK);

  logic [NUM_PINS-1:0] out_q, oe_q, pol_q, lmask_q, emask_q, esel_q;
  logic                top_mask_q;
  logic [NUM_PINS-1:0] sync_q, prev_q, edge_hit, ev_q, ev_clr;
  logic [NUM_PINS-1:0] lvl_pend, edge_pend;
  logic                pend_any;
  logic                wr_pin, wr_top;
  logic [NUM_PINS-1:0] wdat;
  logic [DATA_W-1:0]   rd_mux;

  gpio_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .sync_q(sync_q), .prev_q(prev_q)
  );

  gpio_edge_events #(.W(NUM_PINS)) u_events (
    .clk(clk), .rst(rst), .sync_q(sync_q), .prev_q(prev_q),
    .edge_sel(esel_q), .clr(ev_clr), .hit(edge_hit), .ev_q(ev_q)
  );

  assign wr_pin = bus_valid && bus_write && (bus_region == REGION_PIN);
  assign wr_top = bus_valid && bus_write && (bus_region == REGION_TOP);
  assign wdat   = bus_wdata[NUM_PINS-1:0];
  assign ev_clr = (wr_pin && bus_addr == A_EVT) ? wdat : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q      <= '0;
      oe_q       <= '0;
      pol_q      <= '0;
      lmask_q    <= '0;
      emask_q    <= '0;
      esel_q     <= '0;
      top_mask_q <= 1'b0;
    end else begin
      if (wr_pin) begin
        case (bus_addr)
          A_OUT:   out_q   <= wdat;
          A_OE:    oe_q    <= wdat;
          A_POL:   pol_q   <= wdat;
          A_LMSK:  lmask_q <= wdat;
          A_EMSK:  emask_q <= wdat;
          A_ESEL:  esel_q  <= wdat;
          default: ;
        endcase
      end
      if (wr_top && bus_addr == A_TMSK) top_mask_q <= bus_wdata[0];
    end
  end

  assign lvl_pend  = (sync_q ^ pol_q) & lmask_q;
  assign edge_pend = ev_q & emask_q;
  assign pend_any  = |(lvl_pend | edge_pend);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= pend_any & top_mask_q;
  end

  assign pad_oe  = oe_q;
  assign pad_out = out_q & oe_q;

  always_comb begin
    rd_mux = '0;
    if (bus_region == REGION_PIN) begin
      case (bus_addr)
        A_IN:    rd_mux = DATA_W'(sync_q);
        A_OUT:   rd_mux = DATA_W'(out_q);
        A_OE:    rd_mux = DATA_W'(oe_q);
        A_POL:   rd_mux = DATA_W'(pol_q);
        A_LMSK:  rd_mux = DATA_W'(lmask_q);
        A_EVT:   rd_mux = DATA_W'(ev_q);
        A_EMSK:  rd_mux = DATA_W'(emask_q);
        A_ESEL:  rd_mux = DATA_W'(esel_q);
        default: rd_mux = '0;
      endcase
    end else begin
      case (bus_addr)
        A_TSTS:  rd_mux = DATA_W'(pend_any);
        A_TMSK:  rd_mux = DATA_W'(top_mask_q);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         bus_rdata <= '0;
    else if (bus_valid && !bus_write) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic         irq,
  input logic         pend_any,
  input logic         top_mask_q,
  input logic [W-1:0] edge_hit,
  input logic [W-1:0] ev_q,
  input logic [W-1:0] ev_clr,
  input logic [W-1:0] lmask_q,
  input logic [W-1:0] emask_q
);
  // R3: a released pad never drives a 1
  a_r3_released_pad_low: assert property (@(posedge clk) disable iff (rst)
    (pad_out & ~pad_oe) == '0);

  // R7: every detected edge appears in the event register one cycle later
  a_r7_edge_lands: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(edge_hit) & ~ev_q) == '0));

  // R6: an event bit falls only when a write of 1 targeted it
  a_r6_clear_needs_write: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(ev_q) & ~ev_q) & ~$past(ev_clr)) == '0));

  // R8: with both masks empty nothing can be pending
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (lmask_q == '0 && emask_q == '0) |-> !pend_any);

  // R9: irq follows status AND mask with one register delay
  a_r9_irq_registered: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(pend_any && top_mask_q)));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.W(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq),
  .pend_any(pend_any), .top_mask_q(top_mask_q), .edge_hit(edge_hit),
  .ev_q(ev_q), .ev_clr(ev_clr), .lmask_q(lmask_q), .emask_q(emask_q)
);

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int N  = 8;
  localparam int DW = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_valid = 1'b0, bus_write = 1'b0, bus_region = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pad_out, pad_oe;
  logic          irq;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(N), .DATA_W(DW), .ADDR_W(AW)) u_gpio_irq_ctrl (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_region(bus_region), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic reg_region, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_region = reg_region; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic reg_region, input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_region = reg_region; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] d;
    logic [N-1:0]  pols [4];
    logic [N-1:0]  msks [4];
    pols = '{8'h00, 8'hFF, 8'h5A, 8'h00};
    msks = '{8'hFF, 8'hFF, 8'h0F, 8'h00};

    idle(4);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 pad_oe", DW'(pad_oe), 32'h0);
    for (int a = 0; a < 64; a += 4) begin
      rd(1'b0, AW'(a), d); chk("R1 pin region", d, 32'h0);
      rd(1'b1, AW'(a), d); chk("R1 top region", d, 32'h0);
    end

    // R2: writes to the input register are ignored
    wr(1'b0, 6'h00, 32'hFFFF_FFFF);
    rd(1'b0, 6'h00, d); chk("R2 write ignored", d, 32'h0);

    // R3: pad drive sweep over every enable pattern
    wr(1'b0, 6'h04, 32'h0000_00A5);
    for (int oe = 0; oe < 256; oe++) begin
      wr(1'b0, 6'h08, DW'(oe));
      chk("R3 pad_oe", DW'(pad_oe), DW'(oe));
      chk("R3 pad_out", DW'(pad_out), DW'(oe & 8'hA5));
    end
    rd(1'b0, 6'h04, d); chk("R3 out readback", d, 32'hA5);
    // R11: upper bits are not stored
    wr(1'b0, 6'h10, 32'hFFFF_FF00);
    rd(1'b0, 6'h10, d); chk("R11 upper bits zero", d, 32'h0);

    // R2 and R4: sweep all pin values under several polarity/mask pairs
    for (int p = 0; p < 4; p++) begin
      wr(1'b0, 6'h10, DW'(pols[p]));
      wr(1'b0, 6'h14, DW'(msks[p]));
      for (int v = 0; v < 256; v++) begin
        pin_in = N'(v);
        idle(3);
        rd(1'b0, 6'h00, d); chk("R2 input readback", d, DW'(v));
        rd(1'b1, 6'h20, d);
        chk("R4 level status", d, DW'(|((N'(v) ^ pols[p]) & msks[p])));
      end
    end
    wr(1'b0, 6'h14, 32'h0);
    wr(1'b0, 6'h10, 32'h0);

    // R5, R6: per pin, both edge kinds
    for (int s = 0; s < 2; s++) begin
      wr(1'b0, 6'h24, s ? 32'hFF : 32'h00);
      for (int i = 0; i < N; i++) begin
        pin_in = s ? 8'hFF : 8'h00;
        idle(4);
        wr(1'b0, 6'h18, 32'hFF);
        rd(1'b0, 6'h18, d); chk("R6 cleared", d, 32'h0);
        pin_in[i] = ~pin_in[i];
        idle(4);
        rd(1'b0, 6'h18, d); chk("R5 selected edge", d, DW'(1 << i));
        pin_in[i] = ~pin_in[i];
        idle(4);
        rd(1'b0, 6'h18, d); chk("R5 other edge ignored", d, DW'(1 << i));
        wr(1'b0, 6'h18, DW'(~(1 << i) & 8'hFF));
        rd(1'b0, 6'h18, d); chk("R6 write zero keeps", d, DW'(1 << i));
        wr(1'b0, 6'h18, DW'(1 << i));
        rd(1'b0, 6'h18, d); chk("R6 write one clears", d, 32'h0);
      end
    end

    // R8, R9: edge pending, status and interrupt line
    wr(1'b0, 6'h24, 32'h0);
    pin_in = 8'h00; idle(4);
    pin_in = 8'h01; idle(4);
    rd(1'b1, 6'h20, d); chk("R8 status masked", d, 32'h0);
    wr(1'b0, 6'h1C, 32'h01);
    rd(1'b1, 6'h20, d); chk("R8 status edge", d, 32'h1);
    wr(1'b1, 6'h20, 32'h0);
    rd(1'b1, 6'h20, d); chk("R8 status write ignored", d, 32'h1);
    idle(2);
    chk("R9 irq masked", {31'b0, irq}, 32'h0);
    wr(1'b1, 6'h24, 32'h1);
    idle(1);
    chk("R9 irq raised", {31'b0, irq}, 32'h1);
    rd(1'b1, 6'h24, d); chk("R9 mask readback", d, 32'h1);
    wr(1'b0, 6'h18, 32'h01);
    idle(1);
    chk("R9 irq dropped", {31'b0, irq}, 32'h0);

    // R7: clearing write lands in the same cycle as a new edge
    pin_in = 8'h00; idle(4);
    pin_in = 8'h02; idle(4);
    rd(1'b0, 6'h18, d); chk("R7 preset", d, 32'h2);
    pin_in = 8'h00; idle(4);
    pin_in = 8'h02;              // at a falling edge
    @(posedge clk); @(posedge clk); // second sync stage now high
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_region = 1'b0; bus_addr = 6'h18; bus_wdata = 32'h2;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    rd(1'b0, 6'h18, d); chk("R7 set wins", d, 32'h2);

    // R10: unmapped offsets
    wr(1'b0, 6'h0C, 32'hFFFF_FFFF);
    wr(1'b0, 6'h20, 32'hFFFF_FFFF);
    wr(1'b1, 6'h00, 32'hFFFF_FFFF);
    rd(1'b0, 6'h0C, d); chk("R10 pin 0x0C", d, 32'h0);
    rd(1'b0, 6'h20, d); chk("R10 pin 0x20", d, 32'h0);
    rd(1'b1, 6'h00, d); chk("R10 top 0x00", d, 32'h0);
    rd(1'b0, 6'h04, d); chk("R10 out kept", d, 32'hA5);
    rd(1'b0, 6'h08, d); chk("R10 oe kept", d, 32'hFF);
    rd(1'b0, 6'h14, d); chk("R10 lmask kept", d, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule